// File: doc/BRIEF.md
# Predicated Execute Unit with Condition Flags

This block is the arithmetic and logic stage of a compact 32-bit core. Each cycle it may receive one decoded instruction: a 6-bit operation code, two 32-bit operands that earlier stages have already fetched and sign-extended, a 5-bit destination register number and a 4-bit condition mask. The block holds a private four-flag register (carry, negative, zero, positive) that no instruction can read or write directly. An instruction runs only when every flag that its mask selects is set. A running instruction produces a result in the same cycle, requests a register write-back and overwrites the whole flag register at the next clock edge.

Register and immediate forms of an operation have separate codes but the same behaviour, because the operand is already extracted by the time it reaches this block. Codes that belong to memory or flow-control units pass through as no-ops: they never run here and never touch the flags. The flag register is the only state. It has one reset state (all flags clear) and one transition rule: on each edge it loads the flags of the running instruction, or keeps its value when nothing runs.

Top module: `pexec_unit`

## Requirements
- R1: An instruction with `in_valid` high runs (`out_taken` high) only if every flag picked by `in_cond` is set. Mask bit 3 picks carry, bit 2 negative, bit 1 zero and bit 0 positive. A mask of 0 always runs.
- R2: An instruction that does not run gives no write-back and leaves all four flags unchanged.
- R3: Destination 0 discards the result, so `out_wb_en` stays low. A running instruction aimed at destination 0 still updates the flags.
- R4: Codes 0/1 shift the first operand left and codes 2/3 shift it right, by the number of places given by the whole second operand, filling with zeros. An amount of 32 or more gives 0.
- R5: Codes 4/5 give AND, 6/7 give OR and 8/9 give XOR. Code 10 inverts the first operand, and the second operand has no effect on the result.
- R6: Codes 11/12 add the operands and set carry to the carry out of bit 31. Codes 13/14 give first minus second in two's complement and set carry when a borrow occurs (first below second, unsigned).
- R7: Codes 15/16 give the low 32 bits of the unsigned product and set carry when the upper 32 bits are non-zero.
- R8: After a running instruction, negative, zero and positive describe its 32-bit result read as signed, so exactly one of them is set. Carry is cleared by every operation other than add, subtract and multiply.
- R9: Codes 17 to 63 never run in this block. They give no write-back and leave the flags unchanged.
- R10: Reset clears all four flags, so after reset only instructions with a mask of 0 run.
- R11: When `out_wb_en` is high, `out_wb_dest` equals `in_dest` and `out_result` holds the result of the operation, in the same cycle as the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opcode | input | 6 | Operation code |
| in_cond | input | 4 | Condition mask: bit 3 carry, 2 negative, 1 zero, 0 positive |
| in_dest | input | 5 | Destination register number |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand (register value or extended immediate) |
| out_taken | output | 1 | The instruction runs in this cycle |
| out_wb_en | output | 1 | Register write-back request |
| out_wb_dest | output | 5 | Register to write |
| out_result | output | 32 | Value to write |

## Verification
Two functions collide in a single cycle: the predicate of one instruction reads the flag register, and the instruction before it rewrote that register at the edge just passed. The bench issues instructions back to back, with masks that depend on flags the previous instruction had just set or cleared. It also places skipped instructions, and no-op codes from outside the arithmetic range, between a flag-setting instruction and a later probe. A reference model in the bench keeps its own flag state and predicts each cycle's outcome. A second collision is a write to destination 0 that must suppress the write-back but still rewrite the flags in the same cycle. A follow-up instruction, predicated on the new flags, shows through its taken output whether the flag update happened.

// File: rtl/pexec_pkg.sv
package pexec_pkg;

    localparam int OPC_W  = 6;
    localparam int FLAG_N = 4;

    // bit positions of each flag inside the flag vector and the condition mask
    localparam int FLG_C = 3;
    localparam int FLG_N = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_P = 0;

    typedef enum logic [3:0] {
        FN_SHL,
        FN_SHR,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NOT,
        FN_ADD,
        FN_SUB,
        FN_MUL,
        FN_NONE
    } alu_fn_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
        logic p;
    } flags_t;

    // register and immediate forms share one function
    function automatic alu_fn_e decode_opcode(input logic [OPC_W-1:0] opc);
        alu_fn_e fn;
        case (opc)
            6'd0, 6'd1:   fn = FN_SHL;
            6'd2, 6'd3:   fn = FN_SHR;
            6'd4, 6'd5:   fn = FN_AND;
            6'd6, 6'd7:   fn = FN_OR;
            6'd8, 6'd9:   fn = FN_XOR;
            6'd10:        fn = FN_NOT;
            6'd11, 6'd12: fn = FN_ADD;
            6'd13, 6'd14: fn = FN_SUB;
            6'd15, 6'd16: fn = FN_MUL;
            default:      fn = FN_NONE;
        endcase
        return fn;
    endfunction

endpackage

// File: rtl/pexec_pred.sv
module pexec_pred
    import pexec_pkg::*;
(
    input  flags_t            flags,
    input  logic [FLAG_N-1:0] cond,
    output logic              pass
);

    logic [FLAG_N-1:0] flag_vec;
    logic [FLAG_N-1:0] bit_ok;

    assign flag_vec = flags;

    // each selected flag must be set; unselected flags are don't-care
    for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
        assign bit_ok[i] = ~cond[i] | flag_vec[i];
    end

    assign pass = &bit_ok;

endmodule

// File: rtl/pexec_alu.sv
module pexec_alu
    import pexec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              carry
);

    localparam int SH_W   = $clog2(DATA_W);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   diff_w;
    logic [PROD_W-1:0] prod_w;
    logic              shift_big;
    logic [DATA_W-1:0] shl_w;
    logic [DATA_W-1:0] shr_w;

    assign sum_w     = {1'b0, opa} + {1'b0, opb};
    assign diff_w    = {1'b0, opa} - {1'b0, opb};
    assign prod_w    = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};
    assign shift_big = |opb[DATA_W-1:SH_W];
    assign shl_w     = shift_big ? '0 : (opa << opb[SH_W-1:0]);
    assign shr_w     = shift_big ? '0 : (opa >> opb[SH_W-1:0]);

    always_comb begin
        result = '0;
        carry  = 1'b0;
        unique case (fn)
            FN_SHL: result = shl_w;
            FN_SHR: result = shr_w;
            FN_AND: result = opa & opb;
            FN_OR:  result = opa | opb;
            FN_XOR: result = opa ^ opb;
            FN_NOT: result = ~opa;
            FN_ADD: begin
                result = sum_w[DATA_W-1:0];
                carry  = sum_w[DATA_W];
            end
            FN_SUB: begin
                result = diff_w[DATA_W-1:0];
                carry  = diff_w[DATA_W];
            end
            FN_MUL: begin
                result = prod_w[DATA_W-1:0];
                carry  = |prod_w[PROD_W-1:DATA_W];
            end
            FN_NONE: result = '0;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/pexec_flags.sv
module pexec_flags
    import pexec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    output flags_t            next_flags
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (result == '0);
    assign is_neg  = result[DATA_W-1];

    always_comb begin
        next_flags   = '0;
        next_flags.c = carry;
        next_flags.n = is_neg;
        next_flags.z = is_zero;
        next_flags.p = ~is_neg & ~is_zero;
    end

endmodule

// File: rtl/pexec_unit.sv
module pexec_unit
    import pexec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OPC_W-1:0]     in_opcode,
    input  logic [FLAG_N-1:0]    in_cond,
    input  logic [REG_W-1:0]     in_dest,
    input  logic [DATA_W-1:0]    in_opa,
    input  logic [DATA_W-1:0]    in_opb,
    output logic                 out_taken,
    output logic                 out_wb_en,
    output logic [REG_W-1:0]     out_wb_dest,
    output logic [DATA_W-1:0]    out_result
);

    alu_fn_e           fn;
    logic              is_alu;
    logic              pred_ok;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    flags_t            flag_q;
    flags_t            flag_d;

    assign fn     = decode_opcode(in_opcode);
    assign is_alu = (fn != FN_NONE);

    pexec_pred u_pred (
        .flags (flag_q),
        .cond  (in_cond),
        .pass  (pred_ok)
    );

    pexec_alu #(.DATA_W(DATA_W)) u_alu (
        .fn     (fn),
        .opa    (in_opa),
        .opb    (in_opb),
        .result (alu_res),
        .carry  (alu_carry)
    );

    pexec_flags #(.DATA_W(DATA_W)) u_flags (
        .result     (alu_res),
        .carry      (alu_carry),
        .next_flags (flag_d)
    );

    // flag register: the only state of the block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (out_taken) begin
            flag_q <= flag_d;
        end
    end

    // outputs
    always_comb begin
        out_taken   = in_valid & is_alu & pred_ok;
        out_wb_en   = out_taken & (in_dest != '0);
        out_wb_dest = in_dest;
        out_result  = alu_res;
    end

endmodule

// File: rtl/pexec_checker.sv
module pexec_checker #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [5:0]        in_opcode,
    input logic [3:0]        in_cond,
    input logic [REG_W-1:0]  in_dest,
    input logic              out_taken,
    input logic              out_wb_en,
    input logic [DATA_W-1:0] out_result,
    input logic [3:0]        flag_q
);

    a_r1_pred_selected: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> ((flag_q & in_cond) == in_cond));

    a_r2_skip_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !out_taken |=> $stable(flag_q));

    a_r2_wb_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> out_taken);

    a_r3_dest0_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dest == '0) |-> !out_wb_en);

    a_r8_sign_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flag_q[2:0]) <= 1);

    a_r8_zero_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_taken && out_result == '0) |=> (flag_q[1] && !flag_q[2] && !flag_q[0]));

    a_r9_foreign_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode > 6'd16) |-> (!out_taken && !out_wb_en));

endmodule

bind pexec_unit pexec_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) u_pexec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_opcode  (in_opcode),
    .in_cond    (in_cond),
    .in_dest    (in_dest),
    .out_taken  (out_taken),
    .out_wb_en  (out_wb_en),
    .out_result (out_result),
    .flag_q     (flag_q)
);

// File: tb/pexec_unit_bench.sv
module pexec_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [5:0]  in_opcode;
    logic [3:0]  in_cond;
    logic [4:0]  in_dest;
    logic [31:0] in_opa;
    logic [31:0] in_opb;
    logic        out_taken;
    logic        out_wb_en;
    logic [4:0]  out_wb_dest;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference flag state: {C, N, Z, P}
    logic [3:0] m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    pexec_unit u_pexec_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_opcode  (in_opcode),
        .in_cond    (in_cond),
        .in_dest    (in_dest),
        .in_opa     (in_opa),
        .in_opb     (in_opb),
        .out_taken  (out_taken),
        .out_wb_en  (out_wb_en),
        .out_wb_dest(out_wb_dest),
        .out_result (out_result)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [5:0] opc, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic c, output bit arith);
        logic [63:0] wide;
        r = 0; c = 0; arith = 1;
        case (opc)
            0, 1:   r = (b >= 32) ? 32'd0 : (a << b);
            2, 3:   r = (b >= 32) ? 32'd0 : (a >> b);
            4, 5:   r = a & b;
            6, 7:   r = a | b;
            8, 9:   r = a ^ b;
            10:     r = ~a;
            11, 12: begin wide = {32'd0, a} + {32'd0, b}; r = wide[31:0]; c = wide[32]; end
            13, 14: begin r = a - b; c = (a < b); end
            15, 16: begin wide = {32'd0, a} * {32'd0, b}; r = wide[31:0]; c = (wide[63:32] != 0); end
            default: arith = 0;
        endcase
    endtask

    // one instruction per cycle: drive after falling edge, compare before rising edge
    task automatic issue(input string tag, input logic [5:0] opc, input logic [3:0] cond,
                         input logic [4:0] dest, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic c;
        bit arith, run, wb;
        @(negedge clk);
        in_valid = 1; in_opcode = opc; in_cond = cond; in_dest = dest; in_opa = a; in_opb = b;
        #1;
        model(opc, a, b, r, c, arith);
        run = arith && ((m_flags & cond) == cond);
        wb  = run && (dest != 0);
        check(tag, "taken", {31'd0, out_taken}, {31'd0, run});
        check(tag, "wb_en", {31'd0, out_wb_en}, {31'd0, wb});
        if (wb) begin
            check(tag, "result", out_result, r);
            check(tag, "dest", {27'd0, out_wb_dest}, {27'd0, dest});
        end
        if (run)
            m_flags = {c, r[31], (r == 0), (!r[31] && r != 0)};
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_opcode = 0; in_cond = 0; in_dest = 0; in_opa = 0; in_opb = 0;
        m_flags = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset taken", {31'd0, out_taken}, 32'd0);
        check("R10", "reset wb_en", {31'd0, out_wb_en}, 32'd0);
        rst_n = 1;

        // R10: flags clear after reset, any selected flag blocks execution
        issue("R10", 6'd11, 4'b0010, 5'd1, 32'd1, 32'd1);
        issue("R10", 6'd11, 4'b0001, 5'd1, 32'd1, 32'd1);
        // R6 add, R8 positive
        issue("R6", 6'd11, 4'b0000, 5'd3, 32'd5, 32'd7);
        issue("R1", 6'd12, 4'b0001, 5'd4, 32'd10, 32'd20);
        issue("R1", 6'd11, 4'b0010, 5'd4, 32'd10, 32'd20);
        // R6 subtract with borrow -> C and N
        issue("R6", 6'd13, 4'b0000, 5'd5, 32'd3, 32'd5);
        issue("R1", 6'd14, 4'b1100, 5'd6, 32'd9, 32'd9);
        // R2: now flags C=0 Z=1; skipped ops keep Z
        issue("R2", 6'd11, 4'b1000, 5'd7, 32'd1, 32'd1);
        issue("R2", 6'd4, 4'b0100, 5'd7, 32'd1, 32'd1);
        issue("R2", 6'd7, 4'b0010, 5'd7, 32'h0, 32'hF0);
        // R6 carry out to zero
        issue("R6", 6'd11, 4'b0000, 5'd8, 32'hFFFF_FFFF, 32'd1);
        issue("R1", 6'd9, 4'b1010, 5'd8, 32'h1234, 32'h00FF);
        // R3: destination 0 still updates flags
        issue("R3", 6'd13, 4'b0000, 5'd0, 32'd0, 32'd1);
        issue("R3", 6'd11, 4'b1100, 5'd9, 32'd2, 32'd2);
        // R4 shifts
        issue("R4", 6'd0, 4'b0000, 5'd10, 32'd1, 32'd31);
        issue("R4", 6'd1, 4'b0000, 5'd10, 32'hFFFF_FFFF, 32'd4);
        issue("R4", 6'd2, 4'b0000, 5'd11, 32'h8000_0000, 32'd31);
        issue("R4", 6'd3, 4'b0000, 5'd11, 32'hF000_000F, 32'd4);
        issue("R4", 6'd0, 4'b0000, 5'd12, 32'hFFFF_FFFF, 32'd32);
        issue("R4", 6'd2, 4'b0000, 5'd12, 32'hFFFF_FFFF, 32'h1_0000);
        issue("R4", 6'd3, 4'b0010, 5'd12, 32'hFFFF_FFFF, 32'd0);
        // R5 logic, NOT ignores second operand
        issue("R5", 6'd4, 4'b0000, 5'd13, 32'hF0F0_F0F0, 32'hFF00_FF00);
        issue("R5", 6'd6, 4'b0000, 5'd13, 32'h0F0F_0000, 32'h0000_F0F0);
        issue("R5", 6'd8, 4'b0000, 5'd13, 32'hAAAA_5555, 32'hFFFF_0000);
        issue("R5", 6'd10, 4'b0000, 5'd14, 32'h0000_FFFF, 32'h0);
        issue("R5", 6'd10, 4'b0000, 5'd14, 32'h0000_FFFF, 32'hDEAD_BEEF);
        issue("R5", 6'd10, 4'b0010, 5'd14, 32'hFFFF_FFFF, 32'h1);
        // R7 multiply, overflow into upper half
        issue("R7", 6'd15, 4'b0000, 5'd15, 32'd1000, 32'd1000);
        issue("R7", 6'd16, 4'b0000, 5'd15, 32'h1_0000, 32'h1_0000);
        issue("R7", 6'd4, 4'b1010, 5'd15, 32'h3, 32'h5);
        // R8: logic op clears carry
        issue("R8", 6'd11, 4'b1000, 5'd16, 32'd1, 32'd1);
        // R9: foreign opcodes never run, flags kept
        issue("R9", 6'd17, 4'b0000, 5'd17, 32'd0, 32'd0);
        issue("R9", 6'd63, 4'b0000, 5'd17, 32'd1, 32'd1);
        issue("R9", 6'd11, 4'b0001, 5'd17, 32'd4, 32'd4);
        // R11 plus mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  opc;
            logic [3:0]  cnd;
            logic [31:0] b;
            opc = 6'($urandom_range(0, 20));
            cnd = ($urandom_range(0, 1) == 0) ? 4'b0000 : 4'($urandom_range(0, 15));
            b   = ($urandom_range(0, 2) == 0) ? 32'($urandom_range(0, 40)) : $urandom;
            issue("R11", opc, cnd, 5'($urandom_range(0, 31)), $urandom, b);
        end
        @(negedge clk);
        in_valid = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule